// File: doc/BRIEF.md
# Motor Bridge Power-State and Fault Supervisor

This block decides, cycle by cycle, whether a motor H-bridge may conduct. It takes the chip's active-low reset and sleep pins, plus three digital fault indications produced by analog detectors elsewhere: a supply-undervoltage flag, an over-temperature flag and one current-limit flag per bridge switch. From these it drives the bridge enable, a reset for the rest of the controller's logic, a run enable for the internal clocks and gate-drive charge pump, and an active-low fault indication meant for an open-drain pad.

Each fault class recovers in its own way. An over-temperature condition stops the bridge only while the flag is high. A current limit that persists long enough is latched and stays latched until the reset pin is pulsed or the supply drops out. An undervoltage event takes priority over everything else and behaves like a power cycle. After sleep, reset or undervoltage ends, a settling timer holds the bridge off for a fixed number of cycles so that the charge pump can come up.

Top module: `bridge_supervisor`

## Requirements
- R1: While `rst_n` is low, `logic_rst` is 1 and `bridge_en` is 0, the overcurrent latch is cleared, and `ot_flag` and `ilim_flag` have no effect: `fault_n` stays 1.
- R2: While `sleep_n` is low, `bridge_en` and `core_run` are 0. Over-temperature does not pull `fault_n` low, and `ilim_flag` is not qualified, so no overcurrent latch results from it.
- R3: Once `rst_n` and `sleep_n` are high and `uv_flag` is low, `bridge_en` stays 0 for the first WAKE_CYC rising clock edges. It may go to 1 only after the edge on which that count is reached. Asserting sleep, reset or undervoltage restarts the count.
- R4: If any single bit of `ilim_flag` is high on OC_QUAL consecutive rising edges while the block is awake, the overcurrent latch sets on the last of those edges. From then on `bridge_en` is 0 and `fault_n` is 0.
- R5: If a current-limit bit drops before OC_QUAL consecutive edges, its count returns to zero without latching. A later assertion must then run the full OC_QUAL edges again.
- R6: The overcurrent latch is unaffected by `ilim_flag` going low and by sleep. It is cleared only by `rst_n` low or by `uv_flag`.
- R7: An awake block with `ot_flag` high has `bridge_en` 0 and `fault_n` 0 in the same cycle. Both recover in the cycle in which `ot_flag` falls, with no extra delay.
- R8: `uv_flag` high forces `bridge_en` 0, `core_run` 0 and `logic_rst` 1. Undervoltage on its own leaves `fault_n` at 1. It clears the overcurrent latch and restarts the settling timer.
- R9: Each switch's current-limit flag is qualified on its own. Flags that alternate between different switches never add up to a trip.
- R10: `core_run` is 1 exactly when `sleep_n` is high and `uv_flag` is low, whatever the state of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset pin; clears all state asynchronously |
| sleep_n | input | 1 | Active-low sleep request |
| uv_flag | input | 1 | Supply undervoltage indication, active high |
| ot_flag | input | 1 | Die over-temperature indication, active high |
| ilim_flag | input | NUM_SW | Per-switch current-limit indication, active high |
| bridge_en | output | 1 | Bridge switches may conduct |
| logic_rst | output | 1 | Reset to the controller's other logic, active high |
| core_run | output | 1 | Enable for internal clocks and the charge pump |
| fault_n | output | 1 | Fault indication, low on latched overcurrent or active over-temperature |

## Verification
The three hidden states are the settling count, the per-switch persistence counts and the overcurrent latch. Each of them reaches the ports within one clock edge. A settling count that is off by one moves the first high cycle of `bridge_en` by one cycle. A persistence count that is not cleared, or that is shared between switches, makes `fault_n` fall early or when it should not. A latch that is cleared on the wrong event lifts `fault_n` before reset or undervoltage. The bench drives each of these boundaries edge by edge against a reference model, so any of these faults shows up in the first cycle in which it differs.

// File: rtl/bsup_pkg.sv
package bsup_pkg;

   // Operating condition of the supervised bridge, in priority order.
   typedef enum logic [2:0] {
      PW_OFF    = 3'd0,   // supply below threshold
      PW_HELD   = 3'd1,   // reset pin active
      PW_ASLEEP = 3'd2,   // sleep pin active
      PW_SETTLE = 3'd3,   // awake, charge pump settling
      PW_RUN    = 3'd4    // awake and settled
   } pwr_state_e;

   // Width of a counter that must hold values 0..limit.
   function automatic int cnt_bits(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/bsup_wake_timer.sv
module bsup_wake_timer
   import bsup_pkg::*;
#(
   parameter int WAKE_CYC = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic ready
);

   localparam int CW = cnt_bits(WAKE_CYC);
   localparam logic [CW-1:0] LIM = CW'(WAKE_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (hold)
         cnt_q <= '0;
      else if (cnt_q != LIM)
         cnt_q <= cnt_q + CW'(1);
   end

   assign ready = (cnt_q == LIM);

   generate
      if (WAKE_CYC < 0) begin : g_bad_wake
         $error("WAKE_CYC must not be negative");
      end
      if (WAKE_CYC > 0) begin : g_chk
         AST_SETTLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            hold |=> !ready);                                          // R3
         AST_SETTLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && !hold) |=> ready);                               // R3
      end
   endgenerate

endmodule

// File: rtl/bsup_oc_qual.sv
module bsup_oc_qual
   import bsup_pkg::*;
#(
   parameter int NUM_SW  = 4,
   parameter int OC_QUAL = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              hold,
   input  logic [NUM_SW-1:0] ilim,
   output logic              latch
);

   localparam int CW = cnt_bits(OC_QUAL);
   localparam logic [CW-1:0] LIM = CW'(OC_QUAL);
   localparam logic [CW-1:0] LAST = CW'(OC_QUAL - 1);

   logic [NUM_SW-1:0] hit;

   generate
      if (NUM_SW < 1) begin : g_bad_sw
         $error("NUM_SW must be at least 1");
      end
      if (OC_QUAL < 1) begin : g_bad_qual
         $error("OC_QUAL must be at least 1");
      end

      for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
         if (OC_QUAL == 1) begin : g_direct
            // No persistence: a single sampled edge is enough.
            assign hit[i] = ilim[i] && !clr && !hold;
         end else begin : g_count
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  cnt_q <= '0;
               else if (clr || hold || !ilim[i])
                  cnt_q <= '0;
               else if (cnt_q != LIM)
                  cnt_q <= cnt_q + CW'(1);
            end
            assign hit[i] = ilim[i] && !clr && !hold && (cnt_q == LAST);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         latch <= 1'b0;
      else if (clr)
         latch <= 1'b0;
      else if (|hit)
         latch <= 1'b1;
   end

   AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (latch && !clr) |=> latch);                                      // R6
   AST_UV_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !latch);                                                 // R8
   AST_TRIP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch) |-> $past(|ilim));                                  // R4

endmodule

// File: rtl/bsup_out_gate.sv
module bsup_out_gate
   import bsup_pkg::*;
(
   input  logic       rst_n,
   input  logic       sleep_n,
   input  logic       uv,
   input  logic       ot,
   input  logic       ready,
   input  logic       latch,
   output logic       bridge_en,
   output logic       logic_rst,
   output logic       core_run,
   output logic       fault_n,
   output pwr_state_e state
);

   logic awake;
   logic ot_act;

   always_comb begin
      if (uv)
         state = PW_OFF;
      else if (!rst_n)
         state = PW_HELD;
      else if (!sleep_n)
         state = PW_ASLEEP;
      else if (!ready)
         state = PW_SETTLE;
      else
         state = PW_RUN;
   end

   assign awake     = (state == PW_SETTLE) || (state == PW_RUN);
   assign ot_act    = ot && awake;
   assign bridge_en = (state == PW_RUN) && !latch && !ot;
   assign logic_rst = (state == PW_OFF) || (state == PW_HELD);
   assign core_run  = sleep_n && !uv;
   assign fault_n   = !((latch && rst_n && !uv) || ot_act);

endmodule

// File: rtl/bridge_supervisor.sv
module bridge_supervisor
   import bsup_pkg::*;
#(
   parameter int NUM_SW   = 4,
   parameter int OC_QUAL  = 16,
   parameter int WAKE_CYC = 125000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_n,
   input  logic              uv_flag,
   input  logic              ot_flag,
   input  logic [NUM_SW-1:0] ilim_flag,
   output logic              bridge_en,
   output logic              logic_rst,
   output logic              core_run,
   output logic              fault_n
);

   logic       wake_hold;
   logic       wake_ready;
   logic       oc_latch;
   pwr_state_e pstate;

   assign wake_hold = !sleep_n || uv_flag;

   bsup_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (wake_hold),
      .ready (wake_ready)
   );

   bsup_oc_qual #(.NUM_SW(NUM_SW), .OC_QUAL(OC_QUAL)) u_ocq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (uv_flag),
      .hold  (!sleep_n),
      .ilim  (ilim_flag),
      .latch (oc_latch)
   );

   bsup_out_gate u_gate (
      .rst_n     (rst_n),
      .sleep_n   (sleep_n),
      .uv        (uv_flag),
      .ot        (ot_flag),
      .ready     (wake_ready),
      .latch     (oc_latch),
      .bridge_en (bridge_en),
      .logic_rst (logic_rst),
      .core_run  (core_run),
      .fault_n   (fault_n),
      .state     (pstate)
   );

   AST_SLEEP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |-> (!core_run && !bridge_en));                         // R2
   AST_OT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ot_flag |-> !bridge_en);                                         // R7
   AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |-> (ot_flag || oc_latch));                             // R4
   AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |-> (!bridge_en && logic_rst && fault_n));               // R8
   AST_EN_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      bridge_en |-> (pstate == PW_RUN));                               // R3

endmodule

// File: tb/sim_bridge_supervisor.sv
`timescale 1ns/1ps
module sim_bridge_supervisor;

   localparam int NSW = 4;
   localparam int Q   = 6;
   localparam int W   = 40;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           sleep_n = 1'b0;
   logic           uv_flag = 1'b0;
   logic           ot_flag = 1'b0;
   logic [NSW-1:0] ilim_flag = '0;
   logic           bridge_en, logic_rst, core_run, fault_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   bridge_supervisor #(.NUM_SW(NSW), .OC_QUAL(Q), .WAKE_CYC(W)) u0 (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .uv_flag(uv_flag),
      .ot_flag(ot_flag), .ilim_flag(ilim_flag), .bridge_en(bridge_en),
      .logic_rst(logic_rst), .core_run(core_run), .fault_n(fault_n)
   );

   // ---------------- behavioural reference model ----------------
   int m_wake = 0;
   int m_cnt [NSW];
   bit m_lat  = 1'b0;

   initial foreach (m_cnt[i]) m_cnt[i] = 0;

   always @(posedge clk) begin
      if (!rst_n || uv_flag) begin
         m_wake = 0;
         foreach (m_cnt[i]) m_cnt[i] = 0;
         m_lat = 1'b0;
      end else if (!sleep_n) begin
         m_wake = 0;
         foreach (m_cnt[i]) m_cnt[i] = 0;
      end else begin
         if (m_wake < W) m_wake++;
         foreach (m_cnt[i]) begin
            if (ilim_flag[i]) begin
               m_cnt[i]++;
               if (m_cnt[i] >= Q) m_lat = 1'b1;
            end else begin
               m_cnt[i] = 0;
            end
         end
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      logic awake, e_en, e_rst, e_run, e_flt;
      awake = rst_n && sleep_n && !uv_flag;
      e_en  = awake && (m_wake >= W) && !m_lat && !ot_flag;
      e_rst = !rst_n || uv_flag;
      e_run = sleep_n && !uv_flag;
      e_flt = !((m_lat && rst_n && !uv_flag) || (ot_flag && awake));
      chk("R3", "model bridge_en", bridge_en, e_en);
      chk("R1", "model logic_rst", logic_rst, e_rst);
      chk("R10", "model core_run", core_run, e_run);
      chk("R4", "model fault_n", fault_n, e_flt);
   end

   // Advance n falling edges, then step just past the edge.
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      tick(3);
      chk("R1", "reset logic_rst", logic_rst, 1'b1);
      chk("R1", "reset bridge_en", bridge_en, 1'b0);
      sleep_n = 1'b1; ot_flag = 1'b1; #1;
      chk("R1", "ot ignored in reset", fault_n, 1'b1);
      chk("R10", "core_run in reset", core_run, 1'b1);
      ot_flag = 1'b0;
      tick(1);

      rst_n = 1'b1;
      tick(W - 1);
      chk("R3", "still settling", bridge_en, 1'b0);
      tick(1);
      chk("R3", "settled", bridge_en, 1'b1);

      // R4 qualification boundary
      ilim_flag = 4'b0010;
      tick(Q - 1);
      chk("R4", "no trip before count", fault_n, 1'b1);
      tick(1);
      chk("R4", "trip fault_n", fault_n, 1'b0);
      chk("R4", "trip bridge_en", bridge_en, 1'b0);
      ilim_flag = '0;
      tick(3);
      chk("R6", "latch holds after flag drop", fault_n, 1'b0);
      sleep_n = 1'b0; tick(5);
      sleep_n = 1'b1; tick(5);
      chk("R6", "latch survives sleep", fault_n, 1'b0);
      rst_n = 1'b0; tick(2);
      chk("R1", "reset clears latch", fault_n, 1'b1);
      rst_n = 1'b1; tick(W);
      chk("R3", "resettled after reset", bridge_en, 1'b1);

      // R5 early drop
      ilim_flag = 4'b0100; tick(Q - 1);
      ilim_flag = '0; tick(1);
      ilim_flag = 4'b0100; tick(Q - 1);
      chk("R5", "count restarted", fault_n, 1'b1);
      ilim_flag = '0; tick(1);

      // R9 alternating switches
      for (int k = 0; k < 2 * Q; k++) begin
         ilim_flag = (k % 2 == 0) ? 4'b0001 : 4'b1000;
         tick(1);
      end
      ilim_flag = '0; tick(1);
      chk("R9", "no cross-switch trip", fault_n, 1'b1);

      // R7 over-temperature
      ot_flag = 1'b1; #1;
      chk("R7", "ot fault same cycle", fault_n, 1'b0);
      chk("R7", "ot blocks bridge", bridge_en, 1'b0);
      tick(3);
      ot_flag = 1'b0; #1;
      chk("R7", "ot auto recover", bridge_en, 1'b1);
      chk("R7", "ot fault cleared", fault_n, 1'b1);
      tick(1);

      // R2 sleep ignores inputs
      sleep_n = 1'b0; #1;
      chk("R2", "sleep core_run", core_run, 1'b0);
      chk("R2", "sleep bridge_en", bridge_en, 1'b0);
      ot_flag = 1'b1; ilim_flag = 4'b0001; #1;
      chk("R2", "ot ignored asleep", fault_n, 1'b1);
      tick(Q + 2);
      ot_flag = 1'b0; ilim_flag = '0; sleep_n = 1'b1;
      tick(W);
      chk("R2", "no latch from sleep", fault_n, 1'b1);
      chk("R3", "settled after sleep", bridge_en, 1'b1);

      // R8 undervoltage
      ilim_flag = 4'b0001; tick(Q);
      ilim_flag = '0;
      chk("R4", "second trip", fault_n, 1'b0);
      uv_flag = 1'b1; #1;
      chk("R8", "uv bridge_en", bridge_en, 1'b0);
      chk("R8", "uv core_run", core_run, 1'b0);
      chk("R8", "uv logic_rst", logic_rst, 1'b1);
      chk("R8", "uv alone no fault", fault_n, 1'b1);
      tick(2);
      uv_flag = 1'b0; tick(1);
      chk("R8", "latch cleared by uv", fault_n, 1'b1);
      chk("R8", "settle restarted", bridge_en, 1'b0);
      tick(W - 1);
      chk("R8", "settled after uv", bridge_en, 1'b1);

      tick(2);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule